// File: doc/BRIEF.md
# Real-Time Clock Seconds/Minutes Counter with Round-to-Minute Adjust

This block keeps the seconds and minutes of a real-time clock. It advances on a one-cycle tick that arrives once per second. An 8-bit control register sits beside the counters. Software uses it to start and stop counting, to enable an alarm and an interrupt, to choose a register page, and to request a seconds adjustment. The adjustment rounds the running time to the nearest whole minute.

An adjust request is posted by writing 1 to its bit. Nothing happens at once. The request is applied on the next seconds count-up, which is a tick while counting is enabled. If the seconds are below 30 at that point, they are simply cleared. Otherwise the minutes are advanced and the seconds are cleared. The adjust bit reads back as busy from the write until the count-up that applies it.

The interrupt, clock and alarm enables are protected against being changed together. The clock and alarm enables can only be changed while the interrupt enable is 0. A write that changes either of them leaves the interrupt enable as it was.

Top module: `rtc_adjust_ctrl`

## Requirements
- R1: After reset the register reads 0x00. Seconds and minutes are 0, the minute-carry output is low, and the interrupt output is low.
- R2: With the clock-enable bit (bit 1) set, each tick increments the seconds by one. With that bit clear, ticks leave the seconds and minutes unchanged.
- R3: A tick at second 59 sets the seconds to 0, increments the minutes (59 wraps to 0), and drives the minute-carry output high for exactly one cycle.
- R4: Writing 1 to the adjust bit (bit 3) posts a request, and bit 3 then reads 1. Writing 0 to bit 3 has no effect on a pending request. Bit 3 reads 0 once the request has been applied.
- R5: A pending adjust request is applied only on a count-up. Idle cycles, and ticks while the clock is disabled, leave it pending and leave the time untouched.
- R6: An adjust applied at seconds 0 to 29 clears the seconds, leaves the minutes unchanged, and raises no minute carry.
- R7: An adjust applied at seconds 30 to 59 clears the seconds, increments the minutes, and pulses the minute-carry output.
- R8: The clock-enable bit and the alarm-enable bit (bit 2) change on a write only while the interrupt-enable bit (bit 7) is 0.
- R9: A write whose data differs from the current clock-enable or alarm-enable value leaves the interrupt-enable bit unchanged.
- R10: The interrupt output equals the interrupt request input while bit 7 is 1. It is low while bit 7 is 0.
- R11: The page-select bit (bit 0) is written on every write, reads back, and drives the page output (0 selects page 0, 1 selects page 1).
- R12: Bits 6 to 4 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| irq_req_i | input | 1 | Interrupt source to be gated |
| irq_o | output | 1 | Gated interrupt |
| alarm_en_o | output | 1 | Alarm-enable bit |
| page_o | output | 1 | Page-select bit |
| sec_o | output | 6 | Seconds, 0 to 59 |
| min_o | output | 6 | Minutes, 0 to 59 |
| min_carry_o | output | 1 | One-cycle pulse when the minutes advance |

## Verification
Register writes appear on the read port on the edge that captures them. The bench drives a one-cycle write at a falling edge and reads back at the next falling edge.

A tick is registered on one rising edge. The new seconds, the new minutes, the cleared busy bit and the minute-carry pulse all appear after that edge. The bench therefore checks them half a cycle later, then checks again one cycle on to confirm the carry has dropped.

The interrupt output is combinational from the enable bit and the request input, so it is checked in the cycle the request input is driven.

// File: rtl/rtc_adj_pkg.sv
// Package: shared register layout for the RTC adjust controller.
// Assumes an 8-bit control register; field positions are fixed here only.
package rtc_adj_pkg;
    localparam int CTL_W  = 8;
    localparam int B_PAGE = 0;
    localparam int B_CLK  = 1;
    localparam int B_ALM  = 2;
    localparam int B_ADJ  = 3;
    localparam int B_IE   = 7;
endpackage

// File: rtl/rtc_ctl_reg.sv
// Module: control register with enable interlock and adjust-pending flag.
// Assumes: exec_i pulses on the count-up that consumes a pending adjust.
module rtc_ctl_reg
    import rtc_adj_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    input  logic             exec_i,
    output logic             ie_o,
    output logic             ce_o,
    output logic             ae_o,
    output logic             page_o,
    output logic             pend_o,
    output logic [CTL_W-1:0] rd_o
);
    logic ie_q, ce_q, ae_q, page_q, pend_q;
    logic en_change;
    logic adj_set;

    // Detect a write that would alter the clock or alarm enable.
    always_comb begin
        en_change = (wr_data_i[B_CLK] != ce_q) || (wr_data_i[B_ALM] != ae_q);
        adj_set   = wr_en_i && wr_data_i[B_ADJ];
    end

    // Register update with interlock; adjust flag is set by write-one, cleared by execution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            ce_q   <= 1'b0;
            ae_q   <= 1'b0;
            page_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr_en_i) begin
                page_q <= wr_data_i[B_PAGE];
                if (!ie_q) begin
                    ce_q <= wr_data_i[B_CLK];
                    ae_q <= wr_data_i[B_ALM];
                end
                if (!en_change) begin
                    ie_q <= wr_data_i[B_IE];
                end
            end
            pend_q <= (pend_q && !exec_i) || adj_set;
        end
    end

    // Read view: unused positions stay zero.
    always_comb begin
        rd_o         = '0;
        rd_o[B_PAGE] = page_q;
        rd_o[B_CLK]  = ce_q;
        rd_o[B_ALM]  = ae_q;
        rd_o[B_ADJ]  = pend_q;
        rd_o[B_IE]   = ie_q;
    end

    assign ie_o   = ie_q;
    assign ce_o   = ce_q;
    assign ae_o   = ae_q;
    assign page_o = page_q;
    assign pend_o = pend_q;

    assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && exec_i && !adj_set) |=> !pend_q);
    assert_en_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ie_q) |=> ($stable(ce_q) && $stable(ae_q)));
    assert_ie_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && en_change) |=> $stable(ie_q));
endmodule

// File: rtl/rtc_sec_min_cnt.sv
// Module: modulo-UNITS seconds and minutes counters with round-to-minute adjust.
// Assumes: step_i is a single-cycle count-up; adj_i is sampled only with step_i.
module rtc_sec_min_cnt #(
    parameter int UNITS = 60,
    localparam int CW = $clog2(UNITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          adj_i,
    output logic [CW-1:0] sec_o,
    output logic [CW-1:0] min_o,
    output logic          carry_o
);
    localparam logic [CW-1:0] LAST = CW'(UNITS - 1);
    localparam logic [CW-1:0] HALF = CW'(UNITS / 2);

    logic [CW-1:0] sec_q, min_q;
    logic          carry_q;
    logic [CW-1:0] min_inc;

    // Next minute value with wrap.
    always_comb min_inc = (min_q == LAST) ? '0 : min_q + 1'b1;

    // Counting, rounding adjust and one-cycle carry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= '0;
            min_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            carry_q <= 1'b0;
            if (step_i) begin
                if (adj_i) begin
                    sec_q <= '0;
                    if (sec_q >= HALF) begin
                        min_q   <= min_inc;
                        carry_q <= 1'b1;
                    end
                end else if (sec_q == LAST) begin
                    sec_q   <= '0;
                    min_q   <= min_inc;
                    carry_q <= 1'b1;
                end else begin
                    sec_q <= sec_q + 1'b1;
                end
            end
        end
    end

    assign sec_o   = sec_q;
    assign min_o   = min_q;
    assign carry_o = carry_q;

    assert_sec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q <= LAST) && (min_q <= LAST));
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(sec_q) && $stable(min_q)));
    assert_carry_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |=> !carry_q);
    assert_round_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && adj_i && sec_q < HALF) |=> (sec_q == '0 && !carry_q && $stable(min_q)));
    assert_round_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && adj_i && sec_q >= HALF) |=> (sec_q == '0 && carry_q));
endmodule

// File: rtl/rtc_adjust_ctrl.sv
// Module: top of the RTC seconds/minutes block with round-to-minute adjust.
// Assumes: tick_i is a one-cycle pulse per second, synchronous to clk.
module rtc_adjust_ctrl
    import rtc_adj_pkg::*;
#(
    parameter int UNITS = 60,
    localparam int CW = $clog2(UNITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    output logic [CTL_W-1:0] rd_data_o,
    input  logic             irq_req_i,
    output logic             irq_o,
    output logic             alarm_en_o,
    output logic             page_o,
    output logic [CW-1:0]    sec_o,
    output logic [CW-1:0]    min_o,
    output logic             min_carry_o
);
    logic ie, ce, pend, step;

    // A count-up is a tick while the clock is enabled.
    assign step = tick_i && ce;

    rtc_ctl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .exec_i    (step),
        .ie_o      (ie),
        .ce_o      (ce),
        .ae_o      (alarm_en_o),
        .page_o    (page_o),
        .pend_o    (pend),
        .rd_o      (rd_data_o)
    );

    rtc_sec_min_cnt #(.UNITS(UNITS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .adj_i   (pend),
        .sec_o   (sec_o),
        .min_o   (min_o),
        .carry_o (min_carry_o)
    );

    // Interrupt gate.
    assign irq_o = irq_req_i && ie;

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq_o);
endmodule

// File: tb/rtc_adjust_ctrl_tb.sv
module rtc_adjust_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_req = 1'b0;
    logic       irq;
    logic       alarm_en, page;
    logic [5:0] sec, mins;
    logic       carry;

    int checks = 0;
    int errors = 0;
    int m_sec = 0, m_min = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_adjust_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_req_i(irq_req),
        .irq_o(irq), .alarm_en_o(alarm_en), .page_o(page),
        .sec_o(sec), .min_o(mins), .min_carry_o(carry)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    // One tick with clock enabled; model advances by plain counting (no adjust pending).
    task automatic tick_plain();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        if (m_sec == 59) begin m_sec = 0; m_min = (m_min + 1) % 60; end
        else m_sec++;
    endtask

    task automatic tick_to(input int s);
        while (m_sec != s) tick_plain();
    endtask

    task automatic t_reset();
        irq_req = 1'b1;
        @(negedge clk);
        check(rd_data == 8'h00, "R1 reg", rd_data, 0);
        check(sec == 0 && mins == 0, "R1 time", sec, 0);
        check(!carry, "R1 carry", carry, 0);
        check(!irq, "R1 irq", irq, 0);
        irq_req = 1'b0;
    endtask

    task automatic t_count();
        wr(8'h02);
        tick_plain();
        check(sec == 1, "R2 count", sec, 1);
        wr(8'h00);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check(sec == 1 && mins == 0, "R2 disabled hold", sec, 1);
        wr(8'h02);
    endtask

    task automatic t_wrap();
        tick_to(59);
        check(sec == 59, "R3 at 59", sec, 59);
        tick_plain();
        check(sec == 0 && mins == m_min, "R3 wrap sec", sec, 0);
        check(carry, "R3 carry high", carry, 1);
        @(negedge clk);
        check(!carry, "R3 carry one cycle", carry, 0);
    endtask

    task automatic t_min_wrap();
        while (!(m_min == 59 && m_sec == 59)) tick_plain();
        check(mins == 59, "R3 min 59", mins, 59);
        tick_plain();
        check(mins == 0 && sec == 0 && carry, "R3 min wrap", mins, 0);
    endtask

    // Adjust applied at second s; expect round down below 30, up from 30.
    task automatic t_adjust_at(input int s);
        int exp_min;
        tick_to(s);
        wr(8'h0A);
        check(rd_data[3], "R4 busy set", rd_data[3], 1);
        repeat (3) @(negedge clk);
        check(rd_data[3] && sec == s, "R5 idle keeps pending", sec, s);
        wr(8'h02);
        check(rd_data[3], "R4 write0 no effect", rd_data[3], 1);
        exp_min = (s >= 30) ? (m_min + 1) % 60 : m_min;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        m_sec = 0; m_min = exp_min;
        check(!rd_data[3], "R4 busy cleared", rd_data[3], 0);
        check(sec == 0, (s >= 30) ? "R7 sec cleared" : "R6 sec cleared", sec, 0);
        check(mins == exp_min, (s >= 30) ? "R7 min" : "R6 min", mins, exp_min);
        check(carry == (s >= 30), (s >= 30) ? "R7 carry" : "R6 carry", carry, int'(s >= 30));
    endtask

    task automatic t_adjust_disabled();
        tick_to(10);
        wr(8'h08);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check(rd_data[3] && sec == 10, "R5 tick while disabled", sec, 10);
        wr(8'h02);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        m_sec = 0;
        check(!rd_data[3] && sec == 0, "R5 applied at count-up", sec, 0);
    endtask

    task automatic t_lock();
        wr(8'h82);
        check(rd_data == 8'h82, "R9 ie accepted", rd_data, 8'h82);
        irq_req = 1'b1; #1;
        check(irq, "R10 irq passes", irq, 1);
        wr(8'h80);
        check(rd_data == 8'h82, "R8 clk locked", rd_data, 8'h82);
        wr(8'h86);
        check(rd_data == 8'h82 && !alarm_en, "R8 alarm locked", rd_data, 8'h82);
        wr(8'h00);
        check(rd_data == 8'h82, "R9 ie kept on change", rd_data, 8'h82);
        wr(8'h02);
        check(rd_data == 8'h02, "R8 ie cleared", rd_data, 8'h02);
        check(!irq, "R10 irq gated", irq, 0);
        wr(8'h06);
        check(rd_data == 8'h06 && alarm_en, "R8 alarm set", rd_data, 8'h06);
        wr(8'h82);
        check(rd_data == 8'h02, "R9 ie ignored", rd_data, 8'h02);
        irq_req = 1'b0;
    endtask

    task automatic t_page();
        wr(8'h03);
        check(rd_data == 8'h03 && page, "R11 page1", rd_data, 8'h03);
        wr(8'h73);
        check(rd_data == 8'h03, "R12 unused zero", rd_data, 8'h03);
        wr(8'h02);
        check(!page && rd_data == 8'h02, "R11 page0", rd_data, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_wrap();
        t_adjust_at(0);
        t_adjust_at(29);
        t_adjust_at(30);
        t_adjust_at(59);
        t_adjust_disabled();
        t_min_wrap();
        t_lock();
        t_page();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule